// File: doc/BRIEF.md
# Temperature Alert Output Controller

This block turns a temperature reading and three signed thresholds (upper, lower, critical) into a single alert line for an open-drain pin. The line is given as a pull-down enable: when it is high the pad pulls the wire low, and when it is low the pad releases the wire to its pull-up. The same cycle's comparison results are also brought out as status flags, together with the state of the sticky event latch.

The alert follows one of three behaviours. In window mode (the comparator setting) it tracks the live out-of-window condition. In latched mode (the interrupt setting) a fresh excursion out of the window sets a sticky latch. That latch is cleared either by a configuration-write clear pulse or by the acknowledge of an SMBus Alert Response Address cycle. In critical-only mode the alert reflects nothing but the critical comparison. Whenever the reading is at or above the critical threshold, the alert is held asserted regardless of the selected mode. Once the reading drops back below the critical threshold, the programmed mode takes over again. All outputs are registered, so every output reflects the inputs sampled at the previous rising clock edge.

Top module: `tev_event_ctrl`

## Requirements
- R1: While reset is asserted and before the first clock edge after it, every output is 0 (pin released, all flags clear).
- R2: One clock after the inputs are sampled, st_above_o equals temp > upper, st_below_o equals temp < lower, and st_crit_o equals temp >= critical, all compared as signed two's-complement with the temperature as left operand.
- R3: With irq_mode_i = 0 and crit_only_i = 0 (window mode), evt_pull_o equals the registered (above OR below OR critical) condition, and st_latched_o stays 0.
- R4: With irq_mode_i = 1 and crit_only_i = 0 (latched mode), a cycle in which the reading is out of window while it was in window in the previous sampled cycle sets the latch. evt_pull_o and st_latched_o then stay 1 after the reading returns to the window, for as long as no clear source fires.
- R5: In latched mode, a one-cycle pulse on clr_evt_i clears the latch, and evt_pull_o falls on the next output update when the reading is below critical.
- R6: In latched mode, a one-cycle pulse on ara_ack_i clears the latch in the same way as clr_evt_i.
- R7: In window and latched modes, a reading at or above critical forces evt_pull_o to 1.
- R8: In latched mode, a clear pulse while the reading is at or above critical clears st_latched_o but leaves evt_pull_o at 1 until the reading falls below critical. The pin is then released.
- R9: With crit_only_i = 1, evt_pull_o equals the registered critical condition alone, an out-of-window reading has no effect on it, and st_latched_o is 0.
- R10: In latched mode, a new excursion and a clear pulse in the same cycle leave the latch set.
- R11: In latched mode, a reading that stays out of window does not set the latch again after a clear. Only a fresh in-to-out transition sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | TW | Current temperature, signed |
| lim_hi_i | input | TW | Upper threshold, signed |
| lim_lo_i | input | TW | Lower threshold, signed |
| lim_crit_i | input | TW | Critical threshold, signed |
| irq_mode_i | input | 1 | 1 = latched (interrupt) mode, 0 = window (comparator) mode |
| crit_only_i | input | 1 | 1 = alert on critical condition only |
| clr_evt_i | input | 1 | One-cycle clear pulse from a configuration write |
| ara_ack_i | input | 1 | One-cycle pulse on completion of an Alert Response Address cycle |
| evt_pull_o | output | 1 | Pull-down enable for the open-drain alert pin (1 = drive low) |
| st_above_o | output | 1 | Reading was above the upper threshold |
| st_below_o | output | 1 | Reading was below the lower threshold |
| st_crit_o | output | 1 | Reading was at or above the critical threshold |
| st_latched_o | output | 1 | Sticky event latch state |

## Verification
The assertions assume that both clear inputs are single-cycle pulses, and that the mode and critical-only settings are steady values rather than glitching controls. They also assume the thresholds are ordered so that lower < upper < critical. The stimulus drives each pulse for exactly one applied vector and returns it to 0 on the next one. It changes mode only between groups of vectors, and it uses ordered threshold sets that include negative values so that the signed comparisons are exercised. Exact-threshold readings are applied to probe the strict and non-strict comparisons.

// File: rtl/tev_pkg.sv
package tev_pkg;

    typedef enum logic {
        TEV_WINDOW  = 1'b0,
        TEV_LATCHED = 1'b1
    } tev_mode_e;

    typedef struct packed {
        logic was_out;
        logic latched;
        logic above;
        logic below;
        logic crit;
        logic pull;
    } tev_state_t;

    localparam tev_state_t TEV_STATE_RST = '0;

endpackage

// File: rtl/tev_cmp.sv
module tev_cmp #(
    parameter int TW = 11
) (
    input  logic signed [TW-1:0] temp_i,
    input  logic signed [TW-1:0] lim_hi_i,
    input  logic signed [TW-1:0] lim_lo_i,
    input  logic signed [TW-1:0] lim_crit_i,
    output logic                 above_o,
    output logic                 below_o,
    output logic                 crit_o,
    output logic                 out_o
);

    always_comb begin
        above_o = temp_i > lim_hi_i;
        below_o = temp_i < lim_lo_i;
        crit_o  = temp_i >= lim_crit_i;
        out_o   = above_o | below_o;
    end

endmodule

// File: rtl/tev_core.sv
module tev_core
    import tev_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       above_i,
    input  logic       below_i,
    input  logic       crit_i,
    input  logic       out_i,
    input  tev_mode_e  mode_i,
    input  logic       crit_only_i,
    input  logic       clr_evt_i,
    input  logic       ara_ack_i,
    output tev_state_t state_o
);

    tev_state_t s_d, s_q;
    logic       fresh_exc;
    logic       latch_en;

    always_comb begin
        s_d       = s_q;
        latch_en  = (mode_i == TEV_LATCHED) && !crit_only_i;
        fresh_exc = out_i && !s_q.was_out;

        s_d.above   = above_i;
        s_d.below   = below_i;
        s_d.crit    = crit_i;
        s_d.was_out = out_i;

        if (!latch_en) begin
            s_d.latched = 1'b0;
        end else if (fresh_exc) begin
            s_d.latched = 1'b1;
        end else if (clr_evt_i || ara_ack_i) begin
            s_d.latched = 1'b0;
        end

        if (crit_only_i) begin
            s_d.pull = crit_i;
        end else if (crit_i) begin
            s_d.pull = 1'b1;
        end else if (latch_en) begin
            s_d.pull = s_d.latched;
        end else begin
            s_d.pull = out_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= TEV_STATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o = s_q;

    // R4: a set latch holds while no clear source fires in latched mode
    a_r4_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.latched && latch_en && !clr_evt_i && !ara_ack_i) |=> s_q.latched);

    // R5 / R6: a clear without a fresh excursion empties the latch
    a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clr_evt_i || ara_ack_i) && !(out_i && !s_q.was_out)) |=> !s_q.latched);

    // R10: a fresh excursion in latched mode always sets the latch
    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (latch_en && out_i && !s_q.was_out) |=> s_q.latched);

    // R7: critical condition always drives the pin
    a_r7_crit_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.crit |-> s_q.pull);

    // R9: critical-only mode ignores the window
    a_r9_crit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crit_only_i |=> (s_q.pull == s_q.crit && !s_q.latched));

    // R3: window mode follows the live condition without latching
    a_r3_window_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == TEV_WINDOW && !crit_only_i)
            |=> (s_q.pull == (s_q.above | s_q.below | s_q.crit)) && !s_q.latched);

endmodule

// File: rtl/tev_event_ctrl.sv
module tev_event_ctrl
    import tev_pkg::*;
#(
    parameter int TW = 11
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic signed [TW-1:0] temp_i,
    input  logic signed [TW-1:0] lim_hi_i,
    input  logic signed [TW-1:0] lim_lo_i,
    input  logic signed [TW-1:0] lim_crit_i,
    input  logic                 irq_mode_i,
    input  logic                 crit_only_i,
    input  logic                 clr_evt_i,
    input  logic                 ara_ack_i,
    output logic                 evt_pull_o,
    output logic                 st_above_o,
    output logic                 st_below_o,
    output logic                 st_crit_o,
    output logic                 st_latched_o
);

    logic       cmp_above, cmp_below, cmp_crit, cmp_out;
    tev_state_t st;
    tev_mode_e  mode;

    assign mode = irq_mode_i ? TEV_LATCHED : TEV_WINDOW;

    tev_cmp #(.TW(TW)) u_cmp (
        .temp_i     (temp_i),
        .lim_hi_i   (lim_hi_i),
        .lim_lo_i   (lim_lo_i),
        .lim_crit_i (lim_crit_i),
        .above_o    (cmp_above),
        .below_o    (cmp_below),
        .crit_o     (cmp_crit),
        .out_o      (cmp_out)
    );

    tev_core u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .above_i     (cmp_above),
        .below_i     (cmp_below),
        .crit_i      (cmp_crit),
        .out_i       (cmp_out),
        .mode_i      (mode),
        .crit_only_i (crit_only_i),
        .clr_evt_i   (clr_evt_i),
        .ara_ack_i   (ara_ack_i),
        .state_o     (st)
    );

    assign evt_pull_o   = st.pull;
    assign st_above_o   = st.above;
    assign st_below_o   = st.below;
    assign st_crit_o    = st.crit;
    assign st_latched_o = st.latched;

endmodule

// File: tb/sim_tev_event_ctrl.sv
module sim_tev_event_ctrl;

    localparam int TW = 11;

    logic                 clk = 1'b0;
    logic                 rst_ni = 1'b0;
    logic signed [TW-1:0] temp = '0, hi = '0, lo = '0, cr = '0;
    logic                 irq = 1'b0, conly = 1'b0, clr = 1'b0, ara = 1'b0;
    logic                 pull, ab, be, cri, lat;

    always #2.5 clk = ~clk;

    tev_event_ctrl #(.TW(TW)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .temp_i(temp), .lim_hi_i(hi),
        .lim_lo_i(lo), .lim_crit_i(cr), .irq_mode_i(irq),
        .crit_only_i(conly), .clr_evt_i(clr), .ara_ack_i(ara),
        .evt_pull_o(pull), .st_above_o(ab), .st_below_o(be),
        .st_crit_o(cri), .st_latched_o(lat)
    );

    typedef struct {
        logic  pull, ab, be, cri, lat;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    logic m_out = 1'b0;
    logic m_lat = 1'b0;

    task automatic apply(input int t, input int h, input int l, input int c,
                         input logic im, input logic co,
                         input logic cl, input logic ar, input string tag);
        exp_t e;
        logic o, fresh, len;
        @(negedge clk);
        temp = t[TW-1:0]; hi = h[TW-1:0]; lo = l[TW-1:0]; cr = c[TW-1:0];
        irq = im; conly = co; clr = cl; ara = ar;
        e.ab  = t > h;
        e.be  = t < l;
        e.cri = t >= c;
        o     = e.ab | e.be;
        fresh = o && !m_out;
        len   = im && !co;
        if (!len)           m_lat = 1'b0;
        else if (fresh)     m_lat = 1'b1;
        else if (cl || ar)  m_lat = 1'b0;
        m_out = o;
        e.lat  = m_lat;
        e.pull = co ? e.cri : (e.cri || (len ? m_lat : o));
        e.tag  = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if ({pull, ab, be, cri, lat} !== {e.pull, e.ab, e.be, e.cri, e.lat}) begin
                n_bad++;
                $display("FAIL %s: got pull/ab/be/cri/lat=%b%b%b%b%b expected %b%b%b%b%b",
                         e.tag, pull, ab, be, cri, lat,
                         e.pull, e.ab, e.be, e.cri, e.lat);
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if ({pull, ab, be, cri, lat} !== 5'b0) begin
            n_bad++;
            $display("FAIL R1: got %b%b%b%b%b expected 00000", pull, ab, be, cri, lat);
        end
        @(negedge clk);
        rst_ni = 1'b1;

        // R3 / R2: window mode, thresholds 10..80, critical 100
        apply(40, 80, 10, 100, 0, 0, 0, 0, "R3 in window");
        apply(90, 80, 10, 100, 0, 0, 0, 0, "R3 above");
        apply(5, 80, 10, 100, 0, 0, 0, 0, "R3 below");
        apply(-20, 80, -10, 100, 0, 0, 0, 0, "R2 signed below");
        apply(-5, 80, -10, 100, 0, 0, 0, 0, "R2 signed inside");
        apply(80, 80, 10, 100, 0, 0, 0, 0, "R2 equal upper");
        apply(10, 80, 10, 100, 0, 0, 0, 0, "R2 equal lower");
        apply(100, 80, 10, 100, 0, 0, 0, 0, "R7 equal critical");
        apply(50, 80, 10, 100, 0, 0, 0, 0, "R3 back inside");

        // R4 / R5 / R6: latched mode
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R4 idle");
        apply(90, 80, 10, 100, 1, 0, 0, 0, "R4 set");
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R4 sticky");
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R4 sticky 2");
        apply(50, 80, 10, 100, 1, 0, 1, 0, "R5 clear pulse");
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R5 stays clear");
        apply(-3, 80, 10, 100, 1, 0, 0, 0, "R4 set below");
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R4 sticky below");
        apply(50, 80, 10, 100, 1, 0, 0, 1, "R6 ara clear");
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R6 stays clear");

        // R11: clear while still out of window
        apply(90, 80, 10, 100, 1, 0, 0, 0, "R11 set");
        apply(90, 80, 10, 100, 1, 0, 1, 0, "R11 clear while out");
        apply(95, 80, 10, 100, 1, 0, 0, 0, "R11 no re-set");

        // R10: fresh excursion coincides with clear
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R10 inside");
        apply(90, 80, 10, 100, 1, 0, 1, 0, "R10 set beats clear");
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R10 still set");

        // R8 / R7: critical override in latched mode
        apply(120, 80, 10, 100, 1, 0, 0, 0, "R7 critical");
        apply(120, 80, 10, 100, 1, 0, 1, 0, "R8 clear at critical");
        apply(110, 80, 10, 100, 1, 0, 0, 0, "R8 held at critical");
        apply(50, 80, 10, 100, 1, 0, 0, 0, "R8 released below");
        apply(-50, -20, -40, 30, 1, 0, 0, 0, "R4 signed set");
        apply(40, -20, -40, 30, 1, 0, 0, 1, "R8 ara at critical");
        apply(0, -20, -40, 30, 1, 0, 0, 0, "R8 released signed");

        // R9: critical-only
        apply(50, 80, 10, 100, 1, 1, 0, 0, "R9 inside");
        apply(90, 80, 10, 100, 1, 1, 0, 0, "R9 above ignored");
        apply(5, 80, 10, 100, 0, 1, 0, 0, "R9 below ignored");
        apply(100, 80, 10, 100, 0, 1, 0, 0, "R9 critical");
        apply(60, 80, 10, 100, 0, 1, 0, 0, "R9 released");

        // R3: back to window mode after latched use
        apply(90, 80, 10, 100, 1, 0, 0, 0, "R3 prep latch");
        apply(50, 80, 10, 100, 0, 0, 0, 0, "R3 latch dropped");

        @(negedge clk);
        repeat (2) @(posedge clk);
        #2;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: got %0d pending expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule